// File: doc/BRIEF.md
# Transport Stream Sync Lock and PID Filter

This block sits on a byte-wide MPEG transport stream that arrives with a per-byte valid strobe. It finds the 188-byte packet grid by looking for the sync token 0x47 and keeps track of it. Once it has lock, it pulls a packet identifier out of the first eight bytes of each packet. It then decides whether to pass or drop the whole packet by looking that identifier up in an 8192-entry table that holds one enable bit per identifier. Packets that pass leave the block unchanged, with a marker on their first byte.

The identifier is a programmable bit slice of the packet header, so streams whose identifier sits at a non-standard position can also be filtered. A global enable switches the table lookup off, and then every packet passes. The table is written one 32-bit word at a time through a plain write port.

Internally the output runs eight accepted bytes behind the input. The verdict for a packet can only be taken once its whole header has arrived, and the first byte must not leave before that verdict is known.

Top module: `ts_pid_filter`

## Requirements
- R1: While reset is asserted and after it is released, the block drives `out_valid` and `out_sop` low and is not locked. The table holds all zeros, so every identifier is disabled.
- R2: Lock is declared when nine consecutive packet starts, spaced 188 accepted bytes apart, carry 0x47. Forwarding begins with the packet whose sync byte completed lock. Until then no byte is forwarded.
- R3: While locked, a packet start without 0x47 is a miss, and a correct token clears the miss count. A packet that misses while lock is kept is still forwarded. The ninth consecutive miss drops lock at that packet start, and from that packet on nothing is forwarded until lock is won again.
- R4: The first eight packet bytes form a 64-bit big-endian word, with byte 0 in bits 63:56 and byte 7 in bits 7:0. The identifier is word[off+w-1:off], with `pid_off` as off and `pid_wid` as w. A width above 13 acts as 13. The standard setting is off=40 and w=13.
- R5: The enable bit for identifier p is bit p mod 32 of table word p/32. Writing `tbl_we` replaces that whole word. Bit 31 of word 255 is identifier 8191.
- R6: A packet is forwarded only if `filt_en` is 0 or its table bit is 1. The verdict is taken once, in the cycle the packet's ninth byte is accepted. A table write in that same cycle or later does not affect it, and a packet is always forwarded whole or dropped whole.
- R7: Forwarded bytes leave in order and unchanged. Each one appears on the cycle after the input strobe that accepts the byte eight positions behind it. `out_sop` is high only with the first byte of a packet.
- R8: Cycles with `in_valid` low are ignored whatever `in_data` holds. `out_valid` is low on the cycle after any cycle without a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte strobe |
| in_data | input | 8 | Input stream byte |
| filt_en | input | 1 | 1: use the table; 0: pass every packet |
| pid_off | input | 6 | Bit offset of the identifier slice |
| pid_wid | input | 4 | Bit width of the identifier slice (limited to 13) |
| tbl_we | input | 1 | Table word write strobe |
| tbl_addr | input | 8 | Table word index |
| tbl_wdata | input | 32 | Table word value |
| out_valid | output | 1 | Forwarded byte strobe |
| out_data | output | 8 | Forwarded byte |
| out_sop | output | 1 | First byte of a forwarded packet |

## Verification
The assertions assume that `pid_off` and `pid_wid` stay fixed while a packet's header is waiting for its verdict. They also assume that `filt_en` is steady around verdict cycles. The stimulus changes these inputs only while the stream is idle between packets. The packet-length and lock-edge properties assume each packet runs exactly 188 accepted bytes. The stimulus therefore sends only whole packets, and in payload it replaces 0x47 with another value, so that the search after a lost lock lands on the next real sync byte.

// File: rtl/ts_filt_pkg.sv
package ts_filt_pkg;

  typedef enum logic [1:0] {
    TRK_SEARCH = 2'd0,
    TRK_CHECK  = 2'd1,
    TRK_LOCKED = 2'd2
  } trk_state_e;

  // One byte in the header delay line with its packet tags
  typedef struct packed {
    logic       live;   // byte belongs to a packet received in lock
    logic       head;   // first byte of such a packet
    logic [7:0] data;
  } hdr_slot_t;

endpackage

// File: rtl/ts_sync_tracker.sv
module ts_sync_tracker
  import ts_filt_pkg::*;
#(
  parameter int         PKT_LEN    = 188,
  parameter logic [7:0] SYNC_TOKEN = 8'h47,
  parameter int         LOCK_CNT   = 9,
  parameter int         DROP_CNT   = 9,
  localparam int        POS_W      = $clog2(PKT_LEN),
  localparam int        CNT_MAX    = (LOCK_CNT > DROP_CNT) ? LOCK_CNT : DROP_CNT,
  localparam int        CNT_W      = $clog2(CNT_MAX + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       byte_vld,
  input  logic [7:0] byte_dat,
  output logic       tag_live,
  output logic       tag_head,
  output logic       locked
);

  localparam logic [POS_W-1:0] POS_LAST  = POS_W'(PKT_LEN - 1);
  localparam logic [CNT_W-1:0] LOCK_LAST = CNT_W'(LOCK_CNT - 1);
  localparam logic [CNT_W-1:0] DROP_LAST = CNT_W'(DROP_CNT - 1);

  trk_state_e       st_q, st_d;
  logic [POS_W-1:0] pos_q, pos_d, pos_inc;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             is_tok, at_start;

  always_comb begin
    is_tok   = (byte_dat == SYNC_TOKEN);
    at_start = (pos_q == '0);
    pos_inc  = (pos_q == POS_LAST) ? '0 : pos_q + 1'b1;
    st_d     = st_q;
    pos_d    = pos_q;
    cnt_d    = cnt_q;
    tag_live = 1'b0;
    tag_head = 1'b0;
    if (byte_vld) begin
      unique case (st_q)
        TRK_SEARCH: begin
          if (is_tok) begin
            st_d  = TRK_CHECK;
            pos_d = POS_W'(1);
            cnt_d = CNT_W'(1);
          end
        end
        TRK_CHECK: begin
          pos_d = pos_inc;
          if (at_start) begin
            if (!is_tok) begin
              st_d  = TRK_SEARCH;
              pos_d = '0;
              cnt_d = '0;
            end else if (cnt_q == LOCK_LAST) begin
              st_d     = TRK_LOCKED;
              cnt_d    = '0;
              tag_live = 1'b1;
              tag_head = 1'b1;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        TRK_LOCKED: begin
          pos_d    = pos_inc;
          tag_live = 1'b1;
          if (at_start) begin
            if (is_tok) begin
              cnt_d    = '0;
              tag_head = 1'b1;
            end else if (cnt_q == DROP_LAST) begin
              st_d     = TRK_SEARCH;
              pos_d    = '0;
              cnt_d    = '0;
              tag_live = 1'b0;
            end else begin
              cnt_d    = cnt_q + 1'b1;
              tag_head = 1'b1;
            end
          end
        end
        default: begin
          st_d  = TRK_SEARCH;
          pos_d = '0;
          cnt_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= TRK_SEARCH;
      pos_q <= '0;
      cnt_q <= '0;
    end else if (byte_vld) begin
      st_q  <= st_d;
      pos_q <= pos_d;
      cnt_q <= cnt_d;
    end
  end

  assign locked = (st_q == TRK_LOCKED);

endmodule

// File: rtl/ts_pid_table.sv
module ts_pid_table #(
  parameter int  PID_W  = 13,
  parameter int  WORD_W = 32,
  localparam int DEPTH  = (2 ** PID_W) / WORD_W,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int BIT_W  = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [PID_W-1:0]  rd_pid,
  output logic              rd_hit
);

  logic [WORD_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (wr_en) begin
      mem_q[wr_addr] <= wr_data;
    end
  end

  // Read sees the contents before a write on the same edge
  assign rd_hit = mem_q[rd_pid[PID_W-1:BIT_W]][rd_pid[BIT_W-1:0]];

endmodule

// File: rtl/ts_hdr_pipe.sv
module ts_hdr_pipe
  import ts_filt_pkg::*;
#(
  parameter int  HDR_BYTES = 8,
  parameter int  PID_W     = 13,
  localparam int HDR_W     = HDR_BYTES * 8,
  localparam int OFF_W     = $clog2(HDR_W),
  localparam int WID_W     = $clog2(PID_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift,
  input  hdr_slot_t        in_slot,
  input  logic [OFF_W-1:0] pid_off,
  input  logic [WID_W-1:0] pid_wid,
  output hdr_slot_t        tail,
  output logic [PID_W-1:0] pid
);

  hdr_slot_t        slot_q [HDR_BYTES];
  hdr_slot_t        slot_d [HDR_BYTES];
  logic [HDR_W-1:0] hdr;
  logic [WID_W-1:0] wid_c;

  always_comb begin
    for (int k = 0; k < HDR_BYTES; k++) slot_d[k] = slot_q[k];
    if (shift) begin
      slot_d[0] = in_slot;
      for (int k = 1; k < HDR_BYTES; k++) slot_d[k] = slot_q[k-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < HDR_BYTES; k++) slot_q[k] <= '0;
    end else if (shift) begin
      for (int k = 0; k < HDR_BYTES; k++) slot_q[k] <= slot_d[k];
    end
  end

  // Oldest slot is packet byte 0 and lands in the top bits
  for (genvar g = 0; g < HDR_BYTES; g++) begin : g_hdr
    assign hdr[g*8 +: 8] = slot_q[g].data;
  end

  always_comb begin
    wid_c = (pid_wid > WID_W'(PID_W)) ? WID_W'(PID_W) : pid_wid;
    for (int b = 0; b < PID_W; b++) begin
      if ((WID_W'(b) < wid_c) && ((int'(pid_off) + b) < HDR_W))
        pid[b] = hdr[int'(pid_off) + b];
      else
        pid[b] = 1'b0;
    end
  end

  assign tail = slot_q[HDR_BYTES-1];

endmodule

// File: rtl/ts_pid_filter.sv
module ts_pid_filter
  import ts_filt_pkg::*;
#(
  parameter int         PKT_LEN    = 188,
  parameter logic [7:0] SYNC_TOKEN = 8'h47,
  parameter int         LOCK_CNT   = 9,
  parameter int         DROP_CNT   = 9,
  parameter int         HDR_BYTES  = 8,
  parameter int         PID_W      = 13,
  parameter int         TBL_WORD_W = 32,
  localparam int        TBL_ADDR_W = $clog2((2 ** PID_W) / TBL_WORD_W),
  localparam int        OFF_W      = $clog2(HDR_BYTES * 8),
  localparam int        WID_W      = $clog2(PID_W + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [7:0]            in_data,
  input  logic                  filt_en,
  input  logic [OFF_W-1:0]      pid_off,
  input  logic [WID_W-1:0]      pid_wid,
  input  logic                  tbl_we,
  input  logic [TBL_ADDR_W-1:0] tbl_addr,
  input  logic [TBL_WORD_W-1:0] tbl_wdata,
  output logic                  out_valid,
  output logic [7:0]            out_data,
  output logic                  out_sop
);

  logic             tag_live, tag_head, trk_locked;
  hdr_slot_t        new_slot, tail;
  logic [PID_W-1:0] pid;
  logic             tbl_hit, verdict;
  logic             keep_q, keep_d;
  logic             ov_d, sop_d;
  logic [7:0]       od_d;

  ts_sync_tracker #(
    .PKT_LEN(PKT_LEN), .SYNC_TOKEN(SYNC_TOKEN),
    .LOCK_CNT(LOCK_CNT), .DROP_CNT(DROP_CNT)
  ) u_trk (
    .clk(clk), .rst_n(rst_n), .byte_vld(in_valid), .byte_dat(in_data),
    .tag_live(tag_live), .tag_head(tag_head), .locked(trk_locked)
  );

  assign new_slot = '{live: tag_live, head: tag_head, data: in_data};

  ts_hdr_pipe #(.HDR_BYTES(HDR_BYTES), .PID_W(PID_W)) u_pipe (
    .clk(clk), .rst_n(rst_n), .shift(in_valid), .in_slot(new_slot),
    .pid_off(pid_off), .pid_wid(pid_wid), .tail(tail), .pid(pid)
  );

  ts_pid_table #(.PID_W(PID_W), .WORD_W(TBL_WORD_W)) u_tbl (
    .clk(clk), .rst_n(rst_n), .wr_en(tbl_we), .wr_addr(tbl_addr),
    .wr_data(tbl_wdata), .rd_pid(pid), .rd_hit(tbl_hit)
  );

  always_comb begin
    verdict = !filt_en || tbl_hit;
    keep_d  = keep_q;
    ov_d    = 1'b0;
    sop_d   = 1'b0;
    od_d    = out_data;
    if (in_valid) begin
      od_d = tail.data;
      if (tail.head) begin
        keep_d = verdict;
        ov_d   = verdict;
        sop_d  = verdict;
      end else begin
        ov_d = tail.live && keep_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      keep_q    <= 1'b0;
      out_valid <= 1'b0;
      out_sop   <= 1'b0;
      out_data  <= '0;
    end else begin
      keep_q    <= keep_d;
      out_valid <= ov_d;
      out_sop   <= sop_d;
      out_data  <= od_d;
    end
  end

endmodule

// File: rtl/ts_pid_filter_chk.sv
module ts_pid_filter_chk #(
  parameter int         PKT_LEN    = 188,
  parameter logic [7:0] SYNC_TOKEN = 8'h47,
  localparam int        CW         = $clog2(PKT_LEN + 1)
) (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic [7:0] in_data,
  input logic       locked,
  input logic       out_valid,
  input logic       out_sop
);

  logic [CW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else if (out_valid) run_q <= out_sop ? CW'(1) : run_q + 1'b1;
  end

  AST_SOP_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_sop |-> out_valid);  // R7

  AST_OUT_FOLLOWS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));  // R8

  AST_LOCK_ON_TOKEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> ($past(in_valid) && $past(in_data) == SYNC_TOKEN));  // R2

  AST_UNLOCK_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> ($past(in_valid) && $past(in_data) != SYNC_TOKEN));  // R3

  AST_WHOLE_BEFORE_SOP: assert property (@(posedge clk) disable iff (!rst_n)
    out_sop |-> (run_q == '0 || run_q == CW'(PKT_LEN)));  // R6

  AST_BODY_IN_PACKET: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_sop) |-> (run_q != '0 && run_q < CW'(PKT_LEN)));  // R6

endmodule

bind ts_pid_filter ts_pid_filter_chk #(.PKT_LEN(PKT_LEN), .SYNC_TOKEN(SYNC_TOKEN)) i_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
  .locked(trk_locked), .out_valid(out_valid), .out_sop(out_sop)
);

// File: tb/test_ts_pid_filter.sv
module test_ts_pid_filter;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [7:0]  in_data;
  logic        filt_en;
  logic [5:0]  pid_off;
  logic [3:0]  pid_wid;
  logic        tbl_we;
  logic [7:0]  tbl_addr;
  logic [31:0] tbl_wdata;
  logic        out_valid;
  logic [7:0]  out_data;
  logic        out_sop;

  always #5 clk = ~clk;

  ts_pid_filter i_ts_pid_filter (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .filt_en(filt_en), .pid_off(pid_off), .pid_wid(pid_wid),
    .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata),
    .out_valid(out_valid), .out_data(out_data), .out_sop(out_sop)
  );

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R1";
  int    sop_total = 0;
  int    byte_total = 0;
  bit    gap_mode = 0;
  logic [31:0] lcg = 32'h1234_5678;

  // ---------------- behavioural reference ----------------
  int          q[$];
  int          m_state, m_pos, m_cnt;
  bit          m_keep;
  logic [31:0] m_tab [256];
  bit          exp_v, exp_s;
  logic [7:0]  exp_d;
  bit          b_live, b_head, vd;
  logic [63:0] h;
  int          w, pid, e;

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      m_state = 0; m_pos = 0; m_cnt = 0; m_keep = 0;
      exp_v = 0; exp_s = 0; exp_d = 0;
      for (int i = 0; i < 256; i++) m_tab[i] = 0;
    end else begin
      exp_v = 0; exp_s = 0;
      if (in_valid) begin
        b_live = 0; b_head = 0;
        if (m_state == 0) begin
          if (in_data == 8'h47) begin m_state = 1; m_cnt = 1; m_pos = 1; end
        end else if (m_state == 1) begin
          if (m_pos == 0 && in_data != 8'h47) begin
            m_state = 0; m_cnt = 0; m_pos = 0;
          end else begin
            if (m_pos == 0) begin
              if (m_cnt == 8) begin m_state = 2; m_cnt = 0; b_live = 1; b_head = 1; end
              else m_cnt++;
            end
            m_pos = (m_pos + 1) % 188;
          end
        end else begin
          b_live = 1;
          if (m_pos == 0) begin
            if (in_data == 8'h47) begin m_cnt = 0; b_head = 1; end
            else if (m_cnt == 8) begin m_state = 0; m_cnt = 0; b_live = 0; end
            else begin m_cnt++; b_head = 1; end
          end
          if (m_state == 0) m_pos = 0;
          else m_pos = (m_pos + 1) % 188;
        end
        q.push_back({22'd0, b_head, b_live, in_data});
        if (q.size() > 8) begin
          h = 0;
          for (int k = 0; k < 8; k++) h = {h[55:0], q[k][7:0]};
          w = (pid_wid > 13) ? 13 : int'(pid_wid);
          pid = int'((h >> pid_off) & ((64'd1 << w) - 1));
          vd = !filt_en || m_tab[pid / 32][pid % 32];
          e = q.pop_front();
          if (e[9]) m_keep = vd;
          exp_v = e[8] && m_keep;
          exp_s = e[9] && vd;
          exp_d = e[7:0];
        end
      end
      if (tbl_we) m_tab[tbl_addr] = tbl_wdata;
    end
  end

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (out_valid !== exp_v || out_sop !== exp_s || (exp_v && out_data !== exp_d)) begin
        errors++;
        $display("FAIL %s stream: actual v=%0b d=%h s=%0b expected v=%0b d=%h s=%0b",
                 cur_req, out_valid, out_data, out_sop, exp_v, exp_d, exp_s);
      end
      if (out_valid) byte_total++;
      if (out_valid && out_sop) sop_total++;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic chk(input string req, input string what, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic logic [7:0] rnd();
    lcg = lcg * 32'd1103515245 + 32'd12345;
    return (lcg[23:16] == 8'h47) ? 8'h48 : lcg[23:16];
  endfunction

  task automatic put(input logic [7:0] d, input bit we, input logic [7:0] wa, input logic [31:0] wd);
    @(negedge clk);
    in_valid = 1; in_data = d; tbl_we = we; tbl_addr = wa; tbl_wdata = wd;
    if (gap_mode && (rnd() % 3 == 0)) begin
      @(negedge clk);
      in_valid = 0; in_data = 8'h47; tbl_we = 0;
    end
  endtask

  task automatic send_pkt(input logic [7:0] s, input logic [7:0] b1, input logic [7:0] b2,
                          input logic [7:0] b7, input int wr_at,
                          input logic [7:0] wa, input logic [31:0] wd);
    logic [7:0] d;
    for (int i = 0; i < 188; i++) begin
      if (i == 0) d = s;
      else if (i == 1) d = b1;
      else if (i == 2) d = b2;
      else if (i == 7) d = b7;
      else d = rnd();
      put(d, i == wr_at, wa, wd);
    end
  endtask

  task automatic pid_pkt(input logic [7:0] s, input int p, input int wr_at,
                         input logic [7:0] wa, input logic [31:0] wd);
    send_pkt(s, 8'h40 | 8'(p >> 8), 8'(p), rnd(), wr_at, wa, wd);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 0; in_data = 8'h47; tbl_we = 0;
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    in_valid = 0; tbl_we = 1; tbl_addr = a; tbl_wdata = d;
    @(negedge clk);
    tbl_we = 0;
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  // ---------------- test sequence ----------------
  int s0, b0;
  initial begin
    rst_n = 0; in_valid = 0; in_data = 0; filt_en = 0; pid_off = 6'd40; pid_wid = 4'd13;
    tbl_we = 0; tbl_addr = 0; tbl_wdata = 0;
    repeat (3) @(negedge clk);
    chk("R1", "out_valid in reset", int'(out_valid), 0);
    rst_n = 1;
    idle(2);
    chk("R1", "out_valid after reset", int'(out_valid), 0);
    chk("R1", "out_sop after reset", int'(out_sop), 0);

    // A: acquisition with the filter off
    cur_req = "R2"; s0 = sop_total; b0 = byte_total;
    for (int i = 0; i < 12; i++) pid_pkt(8'h47, 'h100, -1, 0, 0);
    idle(3);
    chk("R2", "packets forwarded after lock", sop_total - s0, 4);
    chk("R7", "bytes forwarded after lock", byte_total - b0, 744);

    // B: table lookup, input gaps with token-valued idle data
    cur_req = "R8"; filt_en = 1;
    wr(8'd8, 32'h1); wr(8'd255, 32'h8000_0000); wr(8'd0, 32'h1);
    gap_mode = 1; s0 = sop_total;
    pid_pkt(8'h47, 'h100, -1, 0, 0);
    pid_pkt(8'h47, 'h101, -1, 0, 0);
    pid_pkt(8'h47, 'h1FFF, -1, 0, 0);
    pid_pkt(8'h47, 'h000, -1, 0, 0);
    pid_pkt(8'h47, 'h1FFE, -1, 0, 0);
    pid_pkt(8'h47, 'h100, -1, 0, 0);
    idle(3); gap_mode = 0;
    chk("R5", "table bit placement", sop_total - s0, 4);

    // C: writes around the verdict point
    cur_req = "R6"; s0 = sop_total;
    pid_pkt(8'h47, 'h101, 3, 8'd8, 32'h3);
    pid_pkt(8'h47, 'h100, 50, 8'd8, 32'h0);
    pid_pkt(8'h47, 'h100, -1, 0, 0);
    pid_pkt(8'h47, 'h101, -1, 0, 0);
    pid_pkt(8'h47, 'h000, 8, 8'd0, 32'h0);
    pid_pkt(8'h47, 'h000, -1, 0, 0);
    idle(3);
    chk("R6", "verdict timing and whole packets", sop_total - s0, 3);

    // D: configurable slice, width limit
    cur_req = "R4"; s0 = sop_total;
    pid_off = 6'd0; pid_wid = 4'd8;
    wr(8'd1, 32'h4); wr(8'd56, 32'h20);
    gap_mode = 1;
    send_pkt(8'h47, 8'h41, 8'h00, 8'h22, -1, 0, 0);
    send_pkt(8'h47, 8'h41, 8'h00, 8'h23, -1, 0, 0);
    send_pkt(8'h47, 8'h41, 8'h00, 8'h22, -1, 0, 0);
    idle(3);
    pid_off = 6'd48; pid_wid = 4'd15;
    send_pkt(8'h47, 8'h05, 8'h00, 8'h11, -1, 0, 0);
    send_pkt(8'h47, 8'h06, 8'h00, 8'h11, -1, 0, 0);
    idle(3); gap_mode = 0;
    chk("R4", "slice selection", sop_total - s0, 3);
    pid_off = 6'd40; pid_wid = 4'd13;

    // E: flywheel and loss of lock
    cur_req = "R3"; filt_en = 0; s0 = sop_total;
    for (int i = 0; i < 8; i++) pid_pkt(8'h46, 'h200, -1, 0, 0);
    pid_pkt(8'h47, 'h200, -1, 0, 0);
    for (int i = 0; i < 9; i++) pid_pkt(8'h46, 'h200, -1, 0, 0);
    idle(3);
    chk("R3", "forwarded through misses until loss", sop_total - s0, 17);
    b0 = byte_total;
    pid_pkt(8'h47, 'h200, -1, 0, 0);
    chk("R3", "bytes while unlocked", byte_total - b0, 0);

    // E2: reacquire (one good packet already counted)
    cur_req = "R2"; s0 = sop_total;
    for (int i = 0; i < 11; i++) pid_pkt(8'h47, 'h200, -1, 0, 0);
    idle(3);
    chk("R2", "packets after reacquisition", sop_total - s0, 4);

    // G: reset clears the table
    cur_req = "R5";
    idle(20);
    rst_n = 0;
    idle(3);
    rst_n = 1;
    filt_en = 1; s0 = sop_total;
    chk("R1", "out_valid after second reset", int'(out_valid), 0);
    for (int i = 0; i < 10; i++) pid_pkt(8'h47, 'h100, -1, 0, 0);
    idle(3);
    chk("R5", "table empty after reset", sop_total - s0, 0);

    summary();
    $finish;
  end

endmodule